// File: doc/BRIEF.md
# Paged 8-bit register file

This block is a 256-entry file of 8-bit registers reached over an 8-bit register address, with a write-data port and a read-data port. Its address space has three regions. The low 224 addresses are plain general-purpose storage. The next sixteen addresses form a system group, which holds control values. The top sixteen addresses are a sliding window onto one bank of sixteen registers, taken from a set of up to 64 banks.

A 6-bit bank selector sits at a fixed slot of the system group. It decides which bank the top window reaches. Writes land on the rising clock edge while write-enable is high. Reads are combinational from the current address. The number of banks that are built is a parameter. A window access to a bank number that was not built reads as zero and drops the write.

A synchronous reset clears the system group and the selector. General-purpose and banked contents keep their values through reset.

Top module: `paged_regfile`

## Requirements
- R1: A write to any address 0..223 is returned by later reads of that address until it is written again.
- R2: `rd_data` follows `reg_addr` combinationally, with no clock edge needed. A rising edge with `wr_en` low changes no register.
- R3: Addresses 224..239 hold system values. All sixteen read 0x00 after a synchronous reset.
- R4: The bank selector is address 225. It keeps `wr_data[5:0]`, reads back with bits 7:6 as zero, and resets to 0.
- R5: Address 240+k reaches slot k of the bank named by the selector. Each bank stores its own sixteen values.
- R6: A selector write changes the bank used by window accesses from the following cycle onward.
- R7: While the selector is at or above NUM_PAGES, window reads return 0x00 and window writes change no stored value.
- R8: Reset leaves general-purpose and banked contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register address for read and write |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |

## Verification
A wrong selector value shows up on the very next window read as data from another bank, or as a zero from a bank that was not built. A window write that aliases into a different bank stays hidden until that bank is selected and read. For that reason the random stimulus switches banks often and re-reads slots that were written earlier. A reset that reaches general or banked storage shows up on the first read after reset.

// File: rtl/prf_pkg.sv
`timescale 1ns/1ps
package prf_pkg;
   typedef enum logic [1:0] {
      REG_GP    = 2'd0,
      REG_SYS   = 2'd1,
      REG_PAGED = 2'd2
   } region_e;
endpackage

// File: rtl/rf_addr_decode.sv
`timescale 1ns/1ps
module rf_addr_decode #(
   parameter int ADDR_W   = 8,
   parameter int GP_COUNT = 224,
   parameter int GRP_SIZE = 16,
   localparam int IDX_W   = $clog2(GRP_SIZE)
) (
   input  logic [ADDR_W-1:0]  addr,
   output prf_pkg::region_e   region,
   output logic [IDX_W-1:0]   grp_idx
);
   localparam int SYS_BASE  = GP_COUNT;
   localparam int PAGE_BASE = GP_COUNT + GRP_SIZE;
   localparam logic [ADDR_W:0] SYS_B = SYS_BASE[ADDR_W:0];
   localparam logic [ADDR_W:0] PG_B  = PAGE_BASE[ADDR_W:0];

   always_comb begin
      if ({1'b0, addr} < SYS_B)     region = prf_pkg::REG_GP;
      else if ({1'b0, addr} < PG_B) region = prf_pkg::REG_SYS;
      else                          region = prf_pkg::REG_PAGED;
   end

   // group bases are aligned, so the slot is the low address bits
   assign grp_idx = addr[IDX_W-1:0];
endmodule

// File: rtl/rf_gp_bank.sv
`timescale 1ns/1ps
module rf_gp_bank #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 224,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   // no reset: contents survive a reset pulse
   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

   AST_GP_WRITE: assert property (@(posedge clk) disable iff (rst)
      we |=> mem[$past(idx)] == $past(wdata)); // R1
endmodule

// File: rtl/rf_sys_group.sv
`timescale 1ns/1ps
module rf_sys_group #(
   parameter int DATA_W   = 8,
   parameter int GRP_SIZE = 16,
   parameter int PTR_W    = 6,
   parameter int PTR_SLOT = 1,
   localparam int IDX_W   = $clog2(GRP_SIZE)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [PTR_W-1:0]  page_ptr
);
   logic [DATA_W-1:0] slot_q [GRP_SIZE];

   for (genvar s = 0; s < GRP_SIZE; s++) begin : g_slot
      if (s == PTR_SLOT) begin : g_ptr
         logic [PTR_W-1:0] ptr_q;
         always_ff @(posedge clk) begin
            if (rst)                            ptr_q <= '0;
            else if (we && idx == IDX_W'(s))    ptr_q <= wdata[PTR_W-1:0];
         end
         assign slot_q[s] = DATA_W'(ptr_q);
         assign page_ptr  = ptr_q;
      end else begin : g_plain
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (rst)                            val_q <= '0;
            else if (we && idx == IDX_W'(s))    val_q <= wdata;
         end
         assign slot_q[s] = val_q;
      end
   end

   assign rdata = slot_q[idx];

   AST_PTR_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> page_ptr == '0); // R4
   AST_SYS_WRITE: assert property (@(posedge clk) disable iff (rst)
      (we && idx != IDX_W'(PTR_SLOT)) |=> slot_q[$past(idx)] == $past(wdata)); // R3
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == IDX_W'(PTR_SLOT)) |=> $stable(page_ptr)); // R6
endmodule

// File: rtl/rf_paged_bank.sv
`timescale 1ns/1ps
module rf_paged_bank #(
   parameter int DATA_W    = 8,
   parameter int GRP_SIZE  = 16,
   parameter int NUM_PAGES = 64,
   parameter int PTR_W     = 6,
   localparam int IDX_W    = $clog2(GRP_SIZE),
   localparam int FLAT_W   = PTR_W + IDX_W,
   localparam int ENTRIES  = NUM_PAGES * GRP_SIZE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [PTR_W-1:0]  page,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic              page_ok;
   logic [FLAT_W-1:0] flat;
   logic [DATA_W-1:0] mem [ENTRIES];

   // a full bank set needs no range check
   if (NUM_PAGES == (1 << PTR_W)) begin : g_full
      assign page_ok = 1'b1;
   end else begin : g_partial
      localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PAGES - 1);
      assign page_ok = (page <= LAST);
   end

   assign flat = {page, idx};

   always_ff @(posedge clk) begin
      if (we && page_ok) mem[flat] <= wdata;
   end

   assign rdata = page_ok ? mem[flat] : '0;

   AST_PG_WRITE: assert property (@(posedge clk) disable iff (rst)
      (we && page_ok) |=> mem[$past(flat)] == $past(wdata)); // R5
endmodule

// File: rtl/paged_regfile.sv
`timescale 1ns/1ps
module paged_regfile #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int GP_COUNT  = 224,
   parameter int GRP_SIZE  = 16,
   parameter int NUM_PAGES = 64,
   parameter int PTR_W     = 6,
   parameter int PTR_SLOT  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        reg_addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data
);
   import prf_pkg::*;

   localparam int IDX_W    = $clog2(GRP_SIZE);
   localparam int PTR_ADDR = GP_COUNT + PTR_SLOT;
   localparam logic [ADDR_W-1:0] PTR_A   = PTR_ADDR[ADDR_W-1:0];
   localparam logic [PTR_W:0]    PAGES_L = NUM_PAGES[PTR_W:0];

   // elaboration-time parameter checks
   if (DATA_W != 8 || ADDR_W != 8) begin : g_bad_width
      $error("paged_regfile: data and address must be 8 bits");
   end
   if ((1 << IDX_W) != GRP_SIZE) begin : g_bad_grp
      $error("paged_regfile: GRP_SIZE must be a power of two");
   end
   if (GP_COUNT % GRP_SIZE != 0 || GP_COUNT + 2 * GRP_SIZE != (1 << ADDR_W)) begin : g_bad_map
      $error("paged_regfile: regions must tile the address space");
   end
   if (NUM_PAGES < 1 || NUM_PAGES > (1 << PTR_W) || PTR_W > 6) begin : g_bad_pages
      $error("paged_regfile: NUM_PAGES out of range");
   end
   if (PTR_SLOT < 0 || PTR_SLOT >= GRP_SIZE || PTR_W > DATA_W) begin : g_bad_slot
      $error("paged_regfile: bad selector placement");
   end

   region_e           region;
   logic [IDX_W-1:0]  grp_idx;
   logic [PTR_W-1:0]  page_ptr;
   logic [DATA_W-1:0] gp_rd, sys_rd, pg_rd;
   logic              gp_we, sys_we, pg_we;

   rf_addr_decode #(.ADDR_W(ADDR_W), .GP_COUNT(GP_COUNT), .GRP_SIZE(GRP_SIZE)) i_dec (
      .addr(reg_addr), .region(region), .grp_idx(grp_idx));

   assign gp_we  = wr_en && (region == REG_GP);
   assign sys_we = wr_en && (region == REG_SYS);
   assign pg_we  = wr_en && (region == REG_PAGED);

   rf_gp_bank #(.DATA_W(DATA_W), .DEPTH(GP_COUNT), .IDX_W(ADDR_W)) i_gp (
      .clk(clk), .rst(rst), .we(gp_we), .idx(reg_addr),
      .wdata(wr_data), .rdata(gp_rd));

   rf_sys_group #(.DATA_W(DATA_W), .GRP_SIZE(GRP_SIZE), .PTR_W(PTR_W),
                  .PTR_SLOT(PTR_SLOT)) i_sys (
      .clk(clk), .rst(rst), .we(sys_we), .idx(grp_idx),
      .wdata(wr_data), .rdata(sys_rd), .page_ptr(page_ptr));

   rf_paged_bank #(.DATA_W(DATA_W), .GRP_SIZE(GRP_SIZE), .NUM_PAGES(NUM_PAGES),
                   .PTR_W(PTR_W)) i_pg (
      .clk(clk), .rst(rst), .we(pg_we), .page(page_ptr), .idx(grp_idx),
      .wdata(wr_data), .rdata(pg_rd));

   always_comb begin
      unique case (region)
         REG_GP:    rd_data = gp_rd;
         REG_SYS:   rd_data = sys_rd;
         default:   rd_data = pg_rd;
      endcase
   end

   AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
      (reg_addr[ADDR_W-1 -: 4] == 4'hF && {1'b0, page_ptr} >= PAGES_L) |-> rd_data == '0); // R7
   AST_PTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_addr == PTR_A) |=> page_ptr == $past(wr_data[PTR_W-1:0])); // R6
   AST_PTR_READBACK: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == PTR_A) |-> rd_data[DATA_W-1:PTR_W] == '0); // R4
endmodule

// File: tb/test_paged_regfile.sv
`timescale 1ns/1ps
module test_paged_regfile;
   localparam int NP = 40;

   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;

   logic [7:0] m_gp [224];
   bit         k_gp [224];
   logic [7:0] m_sys [16];
   logic [7:0] m_pg [64][16];
   bit         k_pg [64][16];
   logic [5:0] m_ptr;

   always #2.5 clk = ~clk;

   paged_regfile #(.NUM_PAGES(NP)) i_paged_regfile (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data));

   function automatic void expect_of(input logic [7:0] a, output logic [7:0] e, output bit k);
      if (a < 224) begin
         e = m_gp[a]; k = k_gp[a];
      end else if (a < 240) begin
         e = m_sys[a - 224]; k = 1'b1;
      end else if (m_ptr >= NP) begin
         e = 8'h00; k = 1'b1;
      end else begin
         e = m_pg[m_ptr][a[3:0]]; k = k_pg[m_ptr][a[3:0]];
      end
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (a < 224) return "R1";
      if (a == 225) return "R4";
      if (a < 240) return "R3";
      if (m_ptr >= NP) return "R7";
      return "R5";
   endfunction

   task automatic compare(input logic [7:0] a, input string tag);
      logic [7:0] e; bit k;
      expect_of(a, e, k);
      if (k) begin
         checks++;
         if (rd_data !== e) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, e);
         end
      end
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      wr_en = 1'b0; reg_addr = a;
      #1 compare(a, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      if (a < 224) begin m_gp[a] = d; k_gp[a] = 1'b1; end
      else if (a < 240) begin
         if (a == 225) begin m_ptr = d[5:0]; m_sys[1] = {2'b00, d[5:0]}; end
         else m_sys[a - 224] = d;
      end else if (m_ptr < NP) begin
         m_pg[m_ptr][a[3:0]] = d; k_pg[m_ptr][a[3:0]] = 1'b1;
      end
      #1 wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0;
      @(posedge clk); @(posedge clk);
      #1 rst = 1'b0;
      for (int i = 0; i < 16; i++) m_sys[i] = 8'h00;
      m_ptr = 6'd0;
   endtask

   initial begin
      #900000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      for (int i = 0; i < 224; i++) k_gp[i] = 1'b0;
      for (int p = 0; p < 64; p++) for (int s = 0; s < 16; s++) k_pg[p][s] = 1'b0;

      do_reset();
      for (int i = 224; i < 240; i++) rd(8'(i), (i == 225) ? "R4" : "R3");

      // R2: combinational read, no edge between address changes
      wr(8'd5, 8'hA5);
      wr(8'd6, 8'h3C);
      @(negedge clk);
      reg_addr = 8'd5; #1 compare(8'd5, "R2");
      reg_addr = 8'd6; #1 compare(8'd6, "R2");
      // R2: edge with wr_en low leaves value
      @(negedge clk);
      reg_addr = 8'd5; wr_data = 8'hFF; wr_en = 1'b0;
      @(posedge clk);
      rd(8'd5, "R2");

      // R4: upper bits dropped
      wr(8'd225, 8'hC3);
      rd(8'd225, "R4");
      // R5: distinct banks
      wr(8'd240, 8'h11);
      wr(8'd225, 8'd4);
      wr(8'd240, 8'h44);
      rd(8'd240, "R5");
      // R6: the read right after the selector write sees the new bank
      wr(8'd225, 8'd3);
      rd(8'd240, "R6");
      // R7: out-of-range bank
      wr(8'd225, 8'd50);
      wr(8'd240, 8'h77);
      rd(8'd240, "R7");
      wr(8'd225, 8'd18);
      wr(8'd240, 8'h18);
      wr(8'd225, 8'd50);
      wr(8'd255, 8'h99);
      rd(8'd255, "R7");
      wr(8'd225, 8'd18);
      rd(8'd240, "R7");
      wr(8'd225, 8'd3);
      rd(8'd240, "R7");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] a;
         int sel;
         sel = $urandom % 8;
         if (sel == 0)      a = 8'd225;
         else if (sel < 3)  a = 8'(240 + ($urandom % 16));
         else               a = 8'($urandom);
         if ($urandom % 2) wr(a, 8'($urandom));
         else              rd(a, tag_of(a));
      end

      // R8: reset keeps general and banked storage
      wr(8'd225, 8'd7);
      wr(8'd244, 8'h5A);
      wr(8'd17, 8'hC6);
      do_reset();
      rd(8'd17, "R8");
      rd(8'd225, "R4");
      wr(8'd225, 8'd7);
      rd(8'd244, "R8");
      for (int i = 0; i < 224; i++) rd(8'(i), "R8");
      do_reset();
      for (int i = 224; i < 240; i++) rd(8'(i), "R3");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule